// File: doc/BRIEF.md
# Ring-Occupancy Interrupt Coalescer

This block sits between the completion logic of a descriptor-ring network interface and its interrupt-cause register. Transmit-done and receive-done events bring in cause bits. The block ORs those bits into one held cause vector and decides, for each event, whether to raise the interrupt now or to keep it for a later flush.

Transmit interrupts are tied to ring occupancy. Each completed pass adds the number of outstanding descriptors to an accumulator. The interrupt is raised only when that accumulator comes close to the ring length. The same accumulator lets the block tell the transmit engine that it may skip a service request while the ring still has plenty of room.

On the receive side, the first event of a window raises the interrupt at once. A low-descriptor condition then raises it once more, and only once. Every other event is held until an idle flush strobe arrives. The flush empties both counters, asks the transmit engine for one service pass and raises the interrupt with the held cause.

Top module: `intr_coalescer`

## Requirements
- R1: The ring length in descriptors is `ring_bytes` shifted right by 4 (16-byte descriptors). The outstanding count is `tail_idx - head_idx`. When the tail is below the head, the ring length is added to that difference.
- R2: A `tx_req` is skipped when the transmit accumulator is above 4 and the accumulator plus the outstanding count is below the ring length minus 5. A request that is not skipped gives a one-cycle `tx_go` pulse on the next cycle.
- R3: A `tx_done` ORs `tx_cause` into the held cause and adds the outstanding count to the accumulator. If the sum reaches the ring length minus 5 or more, the next cycle shows `irq_pulse` with the merged cause on `irq_vec`, and both the accumulator and the held cause are cleared.
- R4: A `tx_done` that does not raise the interrupt marks a flush as pending.
- R5: A receive event ORs `rx_cause` into the held cause. When the receive counter is zero, the interrupt is raised on the next cycle with the merged cause, the held cause is cleared, and the counter becomes 1.
- R6: A receive event with cause bit 4 (low-descriptor threshold) and a receive counter below 100000 raises the interrupt immediately and sets the counter to 100000. A second threshold event in the same window is therefore held and not raised.
- R7: Any other receive event increments the receive counter and marks a flush as pending.
- R8: A flush strobe that finds a pending flush, with at least one counter non-zero, gives `irq_pulse` with the held cause and a `tx_go` pulse on the next cycle. It also clears both counters, the held cause and the pending mark.
- R9: A flush strobe with no pending flush has no effect. A pending flush that finds both counters at zero only clears the pending mark and raises nothing.
- R10: If a flush would execute in a cycle that also carries a transmit-done or receive event, the event is handled first and the flush runs on the next cycle, using the updated state.
- R11: After reset, `irq_pulse`, `irq_vec` and `tx_go` are 0, both counters and the held cause are empty, and no flush is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_bytes | input | 16 | Ring length in bytes |
| head_idx | input | 12 | Ring head index |
| tail_idx | input | 12 | Ring tail index |
| tx_req | input | 1 | Transmit service request strobe |
| tx_done | input | 1 | Transmit pass completed strobe |
| tx_cause | input | 8 | Cause bits of the transmit pass |
| rx_evt | input | 1 | Receive completion strobe |
| rx_cause | input | 8 | Cause bits of the receive event (bit 4: low-descriptor threshold) |
| flush_strobe | input | 1 | Deferred-flush (idle) strobe |
| irq_pulse | output | 1 | One-cycle interrupt assertion |
| irq_vec | output | 8 | Merged cause vector, valid with `irq_pulse`, zero otherwise |
| tx_go | output | 1 | One-cycle permission for a transmit service pass |

## Verification
The assertions assume that the ring holds more than five descriptors and that both indices stay below the ring length. The stimulus therefore uses a fixed 32-descriptor ring and draws indices only from 0 to 31. They also assume that event strobes are single-cycle and are sampled as given, without any handshake. The bench drives every strobe for exactly one clock and holds the ring inputs steady around each edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  parameter int BYTES_W = 16;
  parameter int DESC_SH = 4;
  parameter int IDX_W   = BYTES_W - DESC_SH;
  parameter int CNT_W   = 17;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic idx_t ring_len(input logic [BYTES_W-1:0] bytes);
    return idx_t'(bytes >> DESC_SH);
  endfunction

  function automatic idx_t ring_pending(input idx_t head, input idx_t tail, input idx_t len);
    if (tail >= head) return idx_t'(tail - head);
    return idx_t'(tail + len - head);
  endfunction

  function automatic cnt_t sat_add(input cnt_t a, input cnt_t b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  function automatic cnt_t widen(input idx_t v);
    return cnt_t'(v);
  endfunction
endpackage

// File: rtl/irqc_ring.sv
module irqc_ring
  import irqc_pkg::*;
#(
  parameter int MARGIN = 5
) (
  input  logic [BYTES_W-1:0] ring_bytes,
  input  idx_t               head_idx,
  input  idx_t               tail_idx,
  output idx_t               pending,
  output idx_t               thresh
);
  idx_t len;
  always_comb begin
    len     = ring_len(ring_bytes);
    pending = ring_pending(head_idx, tail_idx, len);
    thresh  = (len > idx_t'(MARGIN)) ? idx_t'(len - idx_t'(MARGIN)) : '0;
  end
endmodule

// File: rtl/irqc_tx.sv
module irqc_tx
  import irqc_pkg::*;
#(
  parameter int BURST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic tx_done,
  input  idx_t pending,
  input  idx_t thresh,
  input  logic clr,
  output logic tx_accept,
  output logic tx_fire,
  output logic tx_sched,
  output logic acc_nz
);
  cnt_t acc;
  cnt_t sum;
  logic near_full;

  always_comb begin
    sum       = sat_add(acc, widen(pending));
    near_full = sum >= widen(thresh);
    tx_fire   = tx_done && near_full;
    tx_sched  = tx_done && !near_full;
    tx_accept = tx_req && !((acc > cnt_t'(BURST)) && !near_full);
    acc_nz    = acc != '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (tx_fire) acc <= '0;
    else if (tx_done) acc <= sum;
    else if (clr)     acc <= '0;
  end

  // R3: a firing pass leaves the accumulator empty
  a_r3_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> !acc_nz);
  // R2: a small accumulator never blocks a request
  a_r2_early_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && acc <= cnt_t'(BURST)) |-> tx_accept);
endmodule

// File: rtl/irqc_rx.sv
module irqc_rx
  import irqc_pkg::*;
#(
  parameter int SENTINEL = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_evt,
  input  logic thr_hit,
  input  logic clr,
  output logic rx_fire,
  output logic rx_sched,
  output logic cnt_nz
);
  localparam cnt_t SENT = cnt_t'(SENTINEL);
  cnt_t cnt;
  logic first, thr_now;

  always_comb begin
    first    = cnt == '0;
    thr_now  = thr_hit && (cnt < SENT);
    rx_fire  = rx_evt && (first || thr_now);
    rx_sched = rx_evt && !rx_fire;
    cnt_nz   = !first;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (rx_evt) begin
      if (first)        cnt <= cnt_t'(1);
      else if (thr_now) cnt <= SENT;
      else              cnt <= sat_add(cnt, cnt_t'(1));
    end else if (clr)   cnt <= '0;
  end

  // R6: once the sentinel is reached no receive event fires
  a_r6_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && cnt >= SENT) |-> !rx_fire);
  // R5: the first event of a window leaves the counter at one
  a_r5_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && first) |=> (cnt == cnt_t'(1)));
endmodule

// File: rtl/intr_coalescer.sv
module intr_coalescer
  import irqc_pkg::*;
#(
  parameter int CAUSE_W  = 8,
  parameter int THR_BIT  = 4,
  parameter int BURST    = 4,
  parameter int MARGIN   = 5,
  parameter int SENTINEL = 100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BYTES_W-1:0] ring_bytes,
  input  logic [IDX_W-1:0]   head_idx,
  input  logic [IDX_W-1:0]   tail_idx,
  input  logic               tx_req,
  input  logic               tx_done,
  input  logic [CAUSE_W-1:0] tx_cause,
  input  logic               rx_evt,
  input  logic [CAUSE_W-1:0] rx_cause,
  input  logic               flush_strobe,
  output logic               irq_pulse,
  output logic [CAUSE_W-1:0] irq_vec,
  output logic               tx_go
);
  idx_t pending, thresh;
  logic tx_accept, tx_fire, tx_sched, acc_nz;
  logic rx_fire, rx_sched, cnt_nz;
  logic pend_flag, flush_due;
  logic [CAUSE_W-1:0] held, held_next;
  logic fire_now, any_evt, flush_req, flush_go, flush_act;

  irqc_ring #(.MARGIN(MARGIN)) u_ring (
    .ring_bytes(ring_bytes), .head_idx(head_idx), .tail_idx(tail_idx),
    .pending(pending), .thresh(thresh));

  irqc_tx #(.BURST(BURST)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_done(tx_done),
    .pending(pending), .thresh(thresh), .clr(flush_act),
    .tx_accept(tx_accept), .tx_fire(tx_fire), .tx_sched(tx_sched), .acc_nz(acc_nz));

  irqc_rx #(.SENTINEL(SENTINEL)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .thr_hit(rx_cause[THR_BIT]),
    .clr(flush_act), .rx_fire(rx_fire), .rx_sched(rx_sched), .cnt_nz(cnt_nz));

  always_comb begin
    held_next = held | (tx_done ? tx_cause : '0) | (rx_evt ? rx_cause : '0);
    fire_now  = tx_fire || rx_fire;
    any_evt   = tx_done || rx_evt;
    flush_req = (flush_strobe && pend_flag) || flush_due;
    flush_go  = flush_req && !any_evt;
    flush_act = flush_go && (acc_nz || cnt_nz);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= '0;
      pend_flag <= 1'b0;
      flush_due <= 1'b0;
      irq_pulse <= 1'b0;
      irq_vec   <= '0;
      tx_go     <= 1'b0;
    end else begin
      held      <= (fire_now || flush_act) ? '0 : held_next;
      pend_flag <= (pend_flag && !flush_go) || tx_sched || rx_sched;
      flush_due <= flush_req && any_evt;
      irq_pulse <= fire_now || flush_act;
      irq_vec   <= fire_now ? held_next : (flush_act ? held : '0);
      tx_go     <= tx_accept || flush_act;
    end
  end

  // R3: a near-full transmit pass reaches the interrupt output
  a_r3_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> irq_pulse);
  // R10: an immediate interrupt never coincides with a flush
  a_r10_priority: assert property (@(posedge clk) disable iff (!rst_n)
    fire_now |-> !flush_act);
  // R8: an executed flush empties both counters
  a_r8_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_act |=> (!acc_nz && !cnt_nz));
  // R9: a flush over empty counters raises nothing
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_go && !acc_nz && !cnt_nz) |=> !irq_pulse);
  // R4: a held transmit pass leaves a flush pending
  a_r4_sched: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sched |=> pend_flag);
endmodule

// File: tb/intr_coalescer_test.sv
module intr_coalescer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ring_bytes = 16'd512;
  logic [11:0] head_idx = '0, tail_idx = '0;
  logic tx_req = 0, tx_done = 0, rx_evt = 0, flush_strobe = 0;
  logic [7:0] tx_cause = '0, rx_cause = '0;
  logic irq_pulse, tx_go;
  logic [7:0] irq_vec;

  always #4 clk = ~clk;

  intr_coalescer uut (
    .clk(clk), .rst_n(rst_n), .ring_bytes(ring_bytes), .head_idx(head_idx),
    .tail_idx(tail_idx), .tx_req(tx_req), .tx_done(tx_done), .tx_cause(tx_cause),
    .rx_evt(rx_evt), .rx_cause(rx_cause), .flush_strobe(flush_strobe),
    .irq_pulse(irq_pulse), .irq_vec(irq_vec), .tx_go(tx_go));

  int checks = 0, errors = 0;
  string cur_req = "R11";
  int m_acc = 0, m_rx = 0, m_held = 0;
  bit m_pend = 0, m_due = 0;
  bit e_irq = 0, e_go = 0;
  int e_vec = 0;
  bit done = 0;

  task automatic model();
    int len, thr, pc, hn, sum, nrx;
    bit txf, rxf, acc, freq, ev, fgo, fact, thr_bit;
    if (!rst_n) begin
      m_acc = 0; m_rx = 0; m_held = 0; m_pend = 0; m_due = 0;
      e_irq = 0; e_go = 0; e_vec = 0;
      return;
    end
    len = ring_bytes / 16;
    thr = (len > 5) ? len - 5 : 0;
    pc  = (tail_idx >= head_idx) ? tail_idx - head_idx : tail_idx + len - head_idx;
    hn  = m_held | (tx_done ? tx_cause : 0) | (rx_evt ? rx_cause : 0);
    sum = m_acc + pc;
    if (sum > 131071) sum = 131071;
    thr_bit = rx_cause[4];
    txf  = tx_done && sum >= thr;
    rxf  = rx_evt && (m_rx == 0 || (thr_bit && m_rx < 100000));
    acc  = tx_req && !(m_acc > 4 && sum < thr);
    freq = (flush_strobe && m_pend) || m_due;
    ev   = tx_done || rx_evt;
    fgo  = freq && !ev;
    fact = fgo && (m_acc > 0 || m_rx > 0);
    e_irq = txf || rxf || fact;
    e_vec = (txf || rxf) ? hn : (fact ? m_held : 0);
    e_go  = acc || fact;
    m_held = e_irq ? 0 : hn;
    if (txf) m_acc = 0; else if (tx_done) m_acc = sum; else if (fact) m_acc = 0;
    if (rx_evt) begin
      if (m_rx == 0) nrx = 1;
      else if (thr_bit && m_rx < 100000) nrx = 100000;
      else nrx = (m_rx + 1 > 131071) ? 131071 : m_rx + 1;
      m_rx = nrx;
    end else if (fact) m_rx = 0;
    m_pend = (m_pend && !fgo) || (tx_done && !txf) || (rx_evt && !rxf);
    m_due  = freq && ev;
  endtask

  task automatic compare();
    checks++;
    if (irq_pulse !== e_irq || irq_vec !== 8'(e_vec) || tx_go !== e_go) begin
      errors++;
      $display("FAIL %s: irq=%0b vec=%02h go=%0b expected irq=%0b vec=%02h go=%0b",
               cur_req, irq_pulse, irq_vec, tx_go, e_irq, 8'(e_vec), e_go);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic cyc(input bit tr, input bit td, input int tc,
                     input bit re, input int rc, input bit fl);
    tx_req = tr; tx_done = td; tx_cause = 8'(tc);
    rx_evt = re; rx_cause = 8'(rc); flush_strobe = fl;
    step();
    tx_req = 0; tx_done = 0; rx_evt = 0; flush_strobe = 0;
    tx_cause = '0; rx_cause = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cur_req = "R11";
    idle(3);
    rst_n = 1'b1;
    idle(2);
    cur_req = "R5";  cyc(0, 0, 0, 1, 8'h01, 0); idle(1);
    cur_req = "R7";  cyc(0, 0, 0, 1, 8'h02, 0); cyc(0, 0, 0, 1, 8'h08, 0); idle(1);
    cur_req = "R8";  cyc(0, 0, 0, 0, 0, 1); idle(1);
    cur_req = "R9";  cyc(0, 0, 0, 0, 0, 1); idle(1);
    cur_req = "R2";  head_idx = 0; tail_idx = 3;
    cyc(1, 0, 0, 0, 0, 0);
    cur_req = "R4";  cyc(0, 1, 8'h20, 0, 0, 0); cyc(0, 1, 8'h40, 0, 0, 0);
    cur_req = "R2";  cyc(1, 0, 0, 0, 0, 0); idle(1);
    cur_req = "R1";  head_idx = 10; tail_idx = 3;
    cyc(1, 0, 0, 0, 0, 0);
    cur_req = "R3";  cyc(0, 1, 8'h80, 0, 0, 0); idle(1);
    cur_req = "R9";  head_idx = 5; tail_idx = 5;
    cyc(0, 1, 8'h01, 0, 0, 0); cyc(0, 0, 0, 0, 0, 1); idle(1);
    cur_req = "R5";  cyc(0, 0, 0, 1, 8'h04, 0);
    cur_req = "R6";  cyc(0, 0, 0, 1, 8'h11, 0); cyc(0, 0, 0, 1, 8'h10, 0);
    cyc(0, 0, 0, 1, 8'h12, 0); idle(1);
    cur_req = "R10"; cyc(0, 0, 0, 1, 8'h02, 1); idle(2);
    cur_req = "R10"; cyc(0, 0, 0, 1, 8'h01, 0); cyc(0, 0, 0, 1, 8'h02, 0);
    cyc(0, 1, 8'h04, 1, 8'h08, 1); idle(2);
    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      head_idx = 12'($urandom_range(0, 31));
      tail_idx = 12'($urandom_range(0, 31));
      cyc(($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0), int'($urandom_range(0, 255)),
          ($urandom_range(0, 3) == 0), int'($urandom_range(0, 255)), ($urandom_range(0, 5) == 0));
    end
    cur_req = "R11";
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    cur_req = "R5"; cyc(0, 0, 0, 1, 8'h10, 0); idle(1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule